// File: doc/BRIEF.md
# One-Hot Reducing Multiplexer

This combinational block selects among a set of equal-width words using a one-hot select vector that has one bit per word. Every word whose select bit is low is first forced to zero. The surviving words are then merged bit by bit into a single output word. A parameter chooses the Boolean operator used for the merge.

With the default OR operator and exactly one select bit high, the block acts as an ordinary multiplexer. Other operators let a small computation happen as part of the selection. Examples are the parity of several chosen words or an inverted result.

A second parameter chooses how unselected words are zeroed. Both choices produce the same output. There is no clock and no reset.

Top module: `onehot_reduce_mux`

## Requirements
- R1: The input bus packs WORD_N words of WORD_W bits each. Word i occupies bits [i*WORD_W +: WORD_W], so word 0 sits in the least-significant bits. Select bit i belongs to word i.
- R2: A word whose select bit is 0 has no effect on the output. Changing its value with every select input held constant leaves the output unchanged.
- R3: The parameter OP_NAME picks the merge operator: "OR" (the default), "AND", "XOR", "NOR", "NAND" or "XNOR". The output is that operator applied bitwise across all WORD_N gated words. Zeroed words take part in the merge.
- R4: With an all-zero select vector the output is all zeros for OR, AND and XOR, and all ones for NOR, NAND and XNOR.
- R5: With several select bits high, the output is the chosen operator applied over all selected words, together with zeros for the others. No word has priority.
- R6: With exactly one select bit high and the OR operator, the output equals the selected word exactly.
- R7: The parameter GATE_NAME chooses the zeroing circuit: "AND" (the default) or "MUX". The output is identical for both.
- R8: The output follows its inputs within the same evaluation, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_hot | input | WORD_N | One-hot (or multi-hot) select, bit i for word i |
| words_in | input | WORD_W*WORD_N | Packed input words, word 0 in the low bits |
| word_out | output | WORD_W | Merged result of the gated words |

## Verification
The bench walks every select value of a five-word build: the empty select, each single-hot select and every multi-hot combination. For each one it compares six operator variants and the alternate gating variant against a behavioural model.

A design that skipped the zeroing would leak unselected data into OR and XOR results. The bench also rewrites only unselected words to expose such leaks directly.

A design that treated the empty select as "output zero" would fail the NOR, NAND and XNOR cases, which must give all ones. A priority scheme in place of a full merge would miscompare on multi-hot XOR and OR. Swapped word ordering would show up as a wrong word on the single-hot OR cases.

// File: rtl/omr_pkg.sv
package omr_pkg;

    typedef enum logic [1:0] {
        BASE_OR  = 2'd0,
        BASE_AND = 2'd1,
        BASE_XOR = 2'd2
    } base_op_e;

    typedef enum logic {
        ZERO_BY_AND = 1'b0,
        ZERO_BY_MUX = 1'b1
    } zero_style_e;

    typedef struct packed {
        base_op_e base;
        logic     invert;
        logic     legal;
    } merge_cfg_t;

    localparam int NAME_BITS = 64;

    function automatic merge_cfg_t decode_op(input logic [NAME_BITS-1:0] name);
        merge_cfg_t c;
        c.legal  = 1'b1;
        c.invert = 1'b0;
        c.base   = BASE_OR;
        if (name == NAME_BITS'("OR")) begin
            c.base = BASE_OR;
        end else if (name == NAME_BITS'("AND")) begin
            c.base = BASE_AND;
        end else if (name == NAME_BITS'("XOR")) begin
            c.base = BASE_XOR;
        end else if (name == NAME_BITS'("NOR")) begin
            c.base = BASE_OR;  c.invert = 1'b1;
        end else if (name == NAME_BITS'("NAND")) begin
            c.base = BASE_AND; c.invert = 1'b1;
        end else if (name == NAME_BITS'("XNOR")) begin
            c.base = BASE_XOR; c.invert = 1'b1;
        end else begin
            c.legal = 1'b0;
        end
        return c;
    endfunction

    function automatic logic gate_legal(input logic [NAME_BITS-1:0] name);
        return (name == NAME_BITS'("AND")) || (name == NAME_BITS'("MUX"));
    endfunction

    function automatic zero_style_e decode_gate(input logic [NAME_BITS-1:0] name);
        return (name == NAME_BITS'("MUX")) ? ZERO_BY_MUX : ZERO_BY_AND;
    endfunction

endpackage

// File: rtl/omr_gate.sv
module omr_gate
    import omr_pkg::*;
#(
    parameter int          WORD_W = 8,
    parameter zero_style_e STYLE  = ZERO_BY_AND
) (
    input  logic              keep,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o
);
    generate
        if (STYLE == ZERO_BY_MUX) begin : g_mux
            assign word_o = keep ? word_i : '0;
        end else begin : g_and
            assign word_o = word_i & {WORD_W{keep}};
        end
    endgenerate
endmodule

// File: rtl/omr_reduce.sv
module omr_reduce
    import omr_pkg::*;
#(
    parameter int       WORD_W = 8,
    parameter int       WORD_N = 4,
    parameter base_op_e BASE   = BASE_OR,
    parameter bit       INVERT = 1'b0,
    localparam int      BUS_W  = WORD_W * WORD_N
) (
    input  logic [BUS_W-1:0]  gated_i,
    output logic [WORD_W-1:0] merged_o
);
    logic [WORD_W-1:0] last;

    generate
        for (genvar i = 0; i < WORD_N; i++) begin : g_stage
            logic [WORD_W-1:0] acc;
            if (i == 0) begin : g_first
                assign acc = gated_i[0 +: WORD_W];
            end else if (BASE == BASE_AND) begin : g_and
                assign acc = g_stage[i-1].acc & gated_i[i*WORD_W +: WORD_W];
            end else if (BASE == BASE_XOR) begin : g_xor
                assign acc = g_stage[i-1].acc ^ gated_i[i*WORD_W +: WORD_W];
            end else begin : g_or
                assign acc = g_stage[i-1].acc | gated_i[i*WORD_W +: WORD_W];
            end
        end
    endgenerate

    assign last = g_stage[WORD_N-1].acc;

    generate
        if (INVERT) begin : g_inv
            assign merged_o = ~last;
        end else begin : g_pass
            assign merged_o = last;
        end
    endgenerate
endmodule

// File: rtl/onehot_reduce_mux.sv
module onehot_reduce_mux
    import omr_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int WORD_N    = 4,
    parameter     OP_NAME   = "OR",
    parameter     GATE_NAME = "AND",
    localparam int BUS_W    = WORD_W * WORD_N
) (
    input  logic [WORD_N-1:0] sel_hot,
    input  logic [BUS_W-1:0]  words_in,
    output logic [WORD_W-1:0] word_out
);
    localparam merge_cfg_t  CFG   = decode_op(NAME_BITS'(OP_NAME));
    localparam zero_style_e STYLE = decode_gate(NAME_BITS'(GATE_NAME));

    generate
        if (!CFG.legal) begin : g_bad_op
            $error("onehot_reduce_mux: unsupported OP_NAME");
        end
        if (!gate_legal(NAME_BITS'(GATE_NAME))) begin : g_bad_gate
            $error("onehot_reduce_mux: unsupported GATE_NAME");
        end
        if (WORD_W < 1 || WORD_N < 1) begin : g_bad_size
            $error("onehot_reduce_mux: WORD_W and WORD_N must be at least 1");
        end
    endgenerate

    logic [BUS_W-1:0] gated;

    generate
        for (genvar i = 0; i < WORD_N; i++) begin : g_gate
            omr_gate #(.WORD_W(WORD_W), .STYLE(STYLE)) u_gate (
                .keep   (sel_hot[i]),
                .word_i (words_in[i*WORD_W +: WORD_W]),
                .word_o (gated[i*WORD_W +: WORD_W])
            );
        end
    endgenerate

    omr_reduce #(
        .WORD_W (WORD_W),
        .WORD_N (WORD_N),
        .BASE   (CFG.base),
        .INVERT (CFG.invert)
    ) u_reduce (
        .gated_i  (gated),
        .merged_o (word_out)
    );

    always_comb begin
        logic [WORD_W-1:0] pick;
        logic [WORD_W-1:0] any_sel;
        pick    = '0;
        any_sel = '0;
        for (int i = 0; i < WORD_N; i++) begin
            if (sel_hot[i]) begin
                pick    = words_in[i*WORD_W +: WORD_W];
                any_sel = any_sel | words_in[i*WORD_W +: WORD_W];
            end
        end
        if (!$isunknown({sel_hot, words_in, word_out})) begin
            // R4
            idle_out_chk: assert (sel_hot != '0 || word_out == {WORD_W{CFG.invert}})
                else $error("empty select gave wrong output");
            // R6
            single_pass_chk: assert (!($onehot(sel_hot) && CFG.base == BASE_OR && !CFG.invert)
                                     || word_out == pick)
                else $error("single select did not pass word through");
            // R3
            and_annul_chk: assert (!(CFG.base == BASE_AND && sel_hot != '1)
                                   || word_out == {WORD_W{CFG.invert}})
                else $error("AND merge ignored a zeroed word");
            // R5
            or_cover_chk: assert (!(CFG.base == BASE_OR && !CFG.invert)
                                  || (word_out & ~any_sel) == '0)
                else $error("OR merge shows bits of no selected word");
        end
    end
endmodule

// File: tb/sim_onehot_reduce_mux.sv
module sim_onehot_reduce_mux;
    localparam int W = 8;
    localparam int N = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]   sel;
    logic [W*N-1:0] words;
    logic [W-1:0]   y_or, y_and, y_xor, y_nor, y_nand, y_xnor, y_mux;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    onehot_reduce_mux #(.WORD_W(W), .WORD_N(N)) u0 (
        .sel_hot(sel), .words_in(words), .word_out(y_or));
    onehot_reduce_mux #(.WORD_W(W), .WORD_N(N), .OP_NAME("AND")) u_and (
        .sel_hot(sel), .words_in(words), .word_out(y_and));
    onehot_reduce_mux #(.WORD_W(W), .WORD_N(N), .OP_NAME("XOR")) u_xor (
        .sel_hot(sel), .words_in(words), .word_out(y_xor));
    onehot_reduce_mux #(.WORD_W(W), .WORD_N(N), .OP_NAME("NOR")) u_nor (
        .sel_hot(sel), .words_in(words), .word_out(y_nor));
    onehot_reduce_mux #(.WORD_W(W), .WORD_N(N), .OP_NAME("NAND")) u_nand (
        .sel_hot(sel), .words_in(words), .word_out(y_nand));
    onehot_reduce_mux #(.WORD_W(W), .WORD_N(N), .OP_NAME("XNOR")) u_xnor (
        .sel_hot(sel), .words_in(words), .word_out(y_xnor));
    onehot_reduce_mux #(.WORD_W(W), .WORD_N(N), .GATE_NAME("MUX")) u_mux (
        .sel_hot(sel), .words_in(words), .word_out(y_mux));

    // op: 0 OR, 1 AND, 2 XOR, 3 NOR, 4 NAND, 5 XNOR
    function automatic logic [W-1:0] model(int op, logic [N-1:0] s, logic [W*N-1:0] ws);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) begin
            int ones = 0;
            for (int k = 0; k < N; k++)
                if (s[k] && ws[k*W + b]) ones++;
            case (op % 3)
                0: r[b] = (ones > 0);
                1: r[b] = (ones == N);
                default: r[b] = ones[0];
            endcase
            if (op >= 3) r[b] = ~r[b];
        end
        return r;
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (sel=%b)", tag, what, act, exp, sel);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "OR",   y_or,   model(0, sel, words));
        check("R3", "AND",  y_and,  model(1, sel, words));
        check("R3", "XOR",  y_xor,  model(2, sel, words));
        check("R3", "NOR",  y_nor,  model(3, sel, words));
        check("R3", "NAND", y_nand, model(4, sel, words));
        check("R3", "XNOR", y_xnor, model(5, sel, words));
        check("R7", "MUX gating", y_mux, y_or);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] hold;
        sel   = '0;
        words = '0;
        @(posedge clk); #1;
        @(negedge clk);
        // R4: empty select, zero words
        check("R4", "OR idle",   y_or,   8'h00);
        check("R4", "XOR idle",  y_xor,  8'h00);
        check("R4", "AND idle",  y_and,  8'h00);
        check("R4", "NOR idle",  y_nor,  8'hFF);
        check("R4", "NAND idle", y_nand, 8'hFF);
        check("R4", "XNOR idle", y_xnor, 8'hFF);

        // R1 / R6: word i sits at bits i*W, single-hot OR returns it
        @(posedge clk); #1;
        words = 40'h55_44_33_22_11;
        for (int i = 0; i < N; i++) begin
            @(posedge clk); #1;
            sel = N'(1) << i;
            @(negedge clk);
            check("R1", "word order", y_or, 8'(8'h11 * (i + 1)));
            check("R6", "single pass", y_or, words[i*W +: W]);
        end

        // R5 and R4 with live data: sweep every select over many word sets
        for (int rep = 0; rep < 24; rep++) begin
            for (int s = 0; s < (1 << N); s++) begin
                @(posedge clk); #1;
                sel   = N'(s);
                words = {$urandom, $urandom};
                if (rep == 0) words = '1;
                @(negedge clk);
                if (s == 0)             check_all("R4");
                else if ($onehot(sel))  check_all("R6");
                else                    check_all("R5");
            end
        end

        // R2: rewrite only unselected words, output must hold
        for (int s = 1; s < (1 << N) - 1; s += 3) begin
            @(posedge clk); #1;
            sel   = N'(s);
            words = {$urandom, $urandom};
            @(negedge clk);
            hold = y_xor;
            @(posedge clk); #1;
            for (int k = 0; k < N; k++)
                if (!sel[k]) words[k*W +: W] = ~words[k*W +: W];
            @(negedge clk);
            check("R2", "unselected change", y_xor, hold);
        end

        // R8: output follows input with no clock edge in between
        @(negedge clk);
        sel   = 5'b00100;
        words = 40'h00_00_A5_00_00;
        #0.5;
        check("R8", "same evaluation", y_or, 8'hA5);
        words = 40'h00_00_3C_00_00;
        #0.5;
        check("R8", "same evaluation", y_or, 8'h3C);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule